// File: doc/BRIEF.md
# Page Entry Permission Checker

This block takes a page table entry that has already been fetched and decides whether one memory access may use it. With each request strobe it receives the entry, the page size exponent, the virtual address, the access kind (instruction fetch, data load or data store) and the current privilege level. One cycle later it returns a registered result. The result is either a fault code or a physical address with a set of read, write and execute permissions.

The fault checks run in a fixed priority order, and each cause has its own code. A wide entry format carries no-execute, no-read and strict-privilege flags. A narrow format has none of these, and the block treats them as zero. The page number bits that lie between bit 12 and the page size exponent belong to software, so the block clears them before it forms the physical address. A parameter selects the entry format, and other parameters set the bit positions and the widths.

Top module: `pte_perm_checker`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault`, `rsp_pa` and `rsp_perm` are all zero. `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. When `req_valid` is low, the result fields keep their values.
- R2: If the valid flag (entry bit 0) is clear, the result is fault code 1 (invalid), whatever the other bits are.
- R3: A fetch (access code 0) to a valid entry whose no-execute flag (bit 62, wide format) is set gives fault code 2. This check outranks the privilege and dirty checks. The no-execute flag has no effect on loads or stores.
- R4: A load (access code 1, and the reserved code 3, which behaves as a load) to a valid entry whose no-read flag (bit 61, wide format) is set gives fault code 3. This check outranks the privilege check. The no-read flag has no effect on fetches.
- R5: The entry's privilege level is held in bits [3:2]. If the strict flag (bit 63, wide format) is 0, the result is fault code 4 when the current level is numerically greater than the entry level. If the strict flag is 1, the result is fault code 4 when the two levels differ.
- R6: A store (access code 2) to an entry whose dirty flag (bit 1) is clear gives fault code 5. This is the lowest-priority check.
- R7: In the narrow format, the no-execute, no-read and strict flags read as zero.
- R8: When there is no fault (code 0), `rsp_pa` is formed as follows. The page number is entry bits [PA_W-1:12] placed at bit 12, with the bits below the page size exponent cleared. This value is ORed with the virtual address bits below the page size exponent.
- R9: When there is no fault, `rsp_perm` has read (bit 0) set, write (bit 1) equal to the dirty flag, and execute (bit 2) equal to the inverse of the no-execute flag.
- R10: When there is a fault, `rsp_pa` and `rsp_perm` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_pte | input | PTE_W | Page table entry |
| req_ps | input | 5 | Page size exponent, 12 to 30 |
| req_va | input | VA_W | Virtual address |
| req_acc | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| req_plv | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 3 | 0 none, 1 invalid, 2 no-exec, 3 no-read, 4 privilege, 5 dirty |
| rsp_pa | output | PA_W | Physical address |
| rsp_perm | output | 3 | {execute, write, read} |

## Verification
Every result (the strobe, the fault code, the address and the permissions) appears on the first rising edge after the edge that captured a request. The bench drives inputs on the falling edge and holds the strobe for one cycle. It then reads all four result fields on the next falling edge, half a cycle after the register loads. To check that results hold, the bench changes the request inputs while the strobe is low and reads the outputs again over several later falling edges.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [2:0] {
      FLT_NONE    = 3'd0,
      FLT_INVALID = 3'd1,
      FLT_NOEXEC  = 3'd2,
      FLT_NOREAD  = 3'd3,
      FLT_PRIV    = 3'd4,
      FLT_DIRTY   = 3'd5
   } flt_e;

   typedef struct packed {
      logic       valid;
      logic       dirty;
      logic       noexec;
      logic       noread;
      logic       strict;
      logic [1:0] lvl;
   } attr_t;

   localparam int PERM_R = 0;
   localparam int PERM_W = 1;
   localparam int PERM_X = 2;

endpackage

// File: rtl/pte_field_extract.sv
module pte_field_extract
   import pte_chk_pkg::*;
#(
   parameter int PTE_W    = 64,
   parameter bit FMT_WIDE = 1'b1,
   parameter int V_BIT    = 0,
   parameter int D_BIT    = 1,
   parameter int PLV_LSB  = 2,
   parameter int NX_BIT   = 62,
   parameter int NR_BIT   = 61,
   parameter int RPLV_BIT = 63
) (
   input  logic [PTE_W-1:0] pte,
   output attr_t            attr
);

   assign attr.valid = pte[V_BIT];
   assign attr.dirty = pte[D_BIT];
   assign attr.lvl   = pte[PLV_LSB +: 2];

   generate
      if (FMT_WIDE) begin : g_wide
         assign attr.noexec = pte[NX_BIT];
         assign attr.noread = pte[NR_BIT];
         assign attr.strict = pte[RPLV_BIT];
      end else begin : g_narrow
         assign attr.noexec = 1'b0;
         assign attr.noread = 1'b0;
         assign attr.strict = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pte_fault_order.sv
module pte_fault_order
   import pte_chk_pkg::*;
(
   input  attr_t      attr,
   input  logic [1:0] acc,
   input  logic [1:0] cur_plv,
   output flt_e       fault
);

   logic is_fetch;
   logic is_load;
   logic is_store;
   logic priv_bad;

   assign is_fetch = (acc == ACC_FETCH);
   assign is_store = (acc == ACC_STORE);
   assign is_load  = (acc == ACC_LOAD) || (acc == ACC_RSVD);

   always_comb begin
      if (attr.strict) priv_bad = (cur_plv != attr.lvl);
      else             priv_bad = (cur_plv >  attr.lvl);
   end

   always_comb begin
      if (!attr.valid)                   fault = FLT_INVALID;
      else if (is_fetch && attr.noexec)  fault = FLT_NOEXEC;
      else if (is_load && attr.noread)   fault = FLT_NOREAD;
      else if (priv_bad)                 fault = FLT_PRIV;
      else if (is_store && !attr.dirty)  fault = FLT_DIRTY;
      else                               fault = FLT_NONE;
   end

endmodule

// File: rtl/pte_addr_compose.sv
module pte_addr_compose #(
   parameter int PTE_W  = 64,
   parameter int VA_W   = 48,
   parameter int PA_W   = 48,
   parameter int PS_W   = 5,
   parameter int PS_MIN = 12,
   parameter int PS_MAX = 30
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [PS_W-1:0]  ps,
   input  logic [VA_W-1:0]  va,
   output logic [PA_W-1:0]  pa
);

   localparam int PFN_W = PA_W - 12;

   logic [PS_W-1:0] ps_eff;
   logic [PA_W-1:0] one;
   logic [PA_W-1:0] off_mask;
   logic [PA_W-1:0] frame;
   logic [PA_W-1:0] va_ext;

   always_comb begin
      if (ps < PS_W'(PS_MIN))      ps_eff = PS_W'(PS_MIN);
      else if (ps > PS_W'(PS_MAX)) ps_eff = PS_W'(PS_MAX);
      else                         ps_eff = ps;
   end

   assign one      = PA_W'(1);
   assign off_mask = (one << ps_eff) - one;
   assign frame    = {pte[12 +: PFN_W], 12'h000};

   generate
      if (VA_W >= PA_W) begin : g_va_trunc
         assign va_ext = va[PA_W-1:0];
      end else begin : g_va_pad
         assign va_ext = {{(PA_W-VA_W){1'b0}}, va};
      end
   endgenerate

   assign pa = (frame & ~off_mask) | (va_ext & off_mask);

endmodule

// File: rtl/pte_perm_checker.sv
module pte_perm_checker
   import pte_chk_pkg::*;
#(
   parameter int PTE_W    = 64,
   parameter int VA_W     = 48,
   parameter int PA_W     = 48,
   parameter bit FMT_WIDE = 1'b1,
   parameter int V_BIT    = 0,
   parameter int D_BIT    = 1,
   parameter int PLV_LSB  = 2,
   parameter int NX_BIT   = 62,
   parameter int NR_BIT   = 61,
   parameter int RPLV_BIT = 63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [PTE_W-1:0] req_pte,
   input  logic [4:0]       req_ps,
   input  logic [VA_W-1:0]  req_va,
   input  logic [1:0]       req_acc,
   input  logic [1:0]       req_plv,
   output logic             rsp_valid,
   output logic [2:0]       rsp_fault,
   output logic [PA_W-1:0]  rsp_pa,
   output logic [2:0]       rsp_perm
);

   localparam int PS_W   = 5;
   localparam int PS_MIN = 12;
   localparam int PS_MAX = 30;

   generate
      if (PA_W <= PS_MAX || PA_W > PTE_W) begin : g_bad_pa
         $error("PA_W must exceed PS_MAX and fit in PTE_W");
      end
      if (FMT_WIDE && (NX_BIT >= PTE_W || NR_BIT >= PTE_W || RPLV_BIT >= PTE_W)) begin : g_bad_bits
         $error("wide-format flag positions exceed PTE_W");
      end
   endgenerate

   attr_t           attr;
   flt_e            fault_c;
   logic [PA_W-1:0] pa_c;
   logic [2:0]      perm_c;

   pte_field_extract #(
      .PTE_W(PTE_W), .FMT_WIDE(FMT_WIDE), .V_BIT(V_BIT), .D_BIT(D_BIT),
      .PLV_LSB(PLV_LSB), .NX_BIT(NX_BIT), .NR_BIT(NR_BIT), .RPLV_BIT(RPLV_BIT)
   ) u_extract (
      .pte  (req_pte),
      .attr (attr)
   );

   pte_fault_order u_order (
      .attr    (attr),
      .acc     (req_acc),
      .cur_plv (req_plv),
      .fault   (fault_c)
   );

   pte_addr_compose #(
      .PTE_W(PTE_W), .VA_W(VA_W), .PA_W(PA_W),
      .PS_W(PS_W), .PS_MIN(PS_MIN), .PS_MAX(PS_MAX)
   ) u_compose (
      .pte (req_pte),
      .ps  (req_ps),
      .va  (req_va),
      .pa  (pa_c)
   );

   always_comb begin
      perm_c         = '0;
      perm_c[PERM_R] = 1'b1;
      perm_c[PERM_W] = attr.dirty;
      perm_c[PERM_X] = ~attr.noexec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= '0;
         rsp_pa    <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault <= fault_c;
            if (fault_c == FLT_NONE) begin
               rsp_pa   <= pa_c;
               rsp_perm <= perm_c;
            end else begin
               rsp_pa   <= '0;
               rsp_perm <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/pte_perm_checker_sva.sv
module pte_perm_checker_sva #(
   parameter int PTE_W    = 64,
   parameter int VA_W     = 48,
   parameter int PA_W     = 48,
   parameter bit FMT_WIDE = 1'b1,
   parameter int V_BIT    = 0,
   parameter int D_BIT    = 1,
   parameter int NX_BIT   = 62
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [PTE_W-1:0] req_pte,
   input logic [1:0]       req_acc,
   input logic             rsp_valid,
   input logic [2:0]       rsp_fault,
   input logic [PA_W-1:0]  rsp_pa,
   input logic [2:0]       rsp_perm
);

   p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_result_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_fault) && $stable(rsp_pa) && $stable(rsp_perm)));

   p_invalid_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_pte[V_BIT]) |=> (rsp_fault == 3'd1));

   generate
      if (FMT_WIDE) begin : g_wide_chk
         p_noexec_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_pte[V_BIT] && req_acc == 2'd0 && req_pte[NX_BIT])
            |=> (rsp_fault == 3'd2));
      end
   endgenerate

   p_clean_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_pte[V_BIT] && req_acc == 2'd2 && !req_pte[D_BIT])
      |=> (rsp_fault == 3'd4 || rsp_fault == 3'd5));

   p_read_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 3'd0) |-> rsp_perm[0]);

   p_fault_zeroes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == '0 && rsp_perm == 3'd0));

   p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault <= 3'd5);

endmodule

bind pte_perm_checker pte_perm_checker_sva #(
   .PTE_W(PTE_W), .VA_W(VA_W), .PA_W(PA_W), .FMT_WIDE(FMT_WIDE),
   .V_BIT(V_BIT), .D_BIT(D_BIT), .NX_BIT(NX_BIT)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_pte   (req_pte),
   .req_acc   (req_acc),
   .rsp_valid (rsp_valid),
   .rsp_fault (rsp_fault),
   .rsp_pa    (rsp_pa),
   .rsp_perm  (rsp_perm)
);

// File: tb/tb_pte_perm_checker.sv
module tb_pte_perm_checker;

   typedef struct packed {
      logic [35:0] pfn;
      logic [1:0]  lvl;
      logic        v;
      logic        d;
      logic        nx;
      logic        nr;
      logic        rp;
      logic [4:0]  ps;
      logic [47:0] va;
      logic [1:0]  acc;
      logic [1:0]  cur;
      logic [2:0]  ef;
   } vec_t;

   localparam logic [35:0] PF = 36'h9_8765_4FFF;
   localparam logic [47:0] VA = 48'h1234_5678_9ABC;
   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{PF, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 5'd12, VA, 2'd0, 2'd0, 3'd1},
      '{PF, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd12, VA, 2'd0, 2'd3, 3'd2},
      '{PF, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd14, VA, 2'd1, 2'd0, 3'd0},
      '{PF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd12, VA, 2'd1, 2'd2, 3'd3},
      '{PF, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd21, VA, 2'd0, 2'd1, 3'd0},
      '{PF, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd12, VA, 2'd1, 2'd2, 3'd4},
      '{PF, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd16, VA, 2'd1, 2'd1, 3'd0},
      '{PF, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd12, VA, 2'd1, 2'd1, 3'd4},
      '{PF, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd30, VA, 2'd2, 2'd2, 3'd0},
      '{PF, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd12, VA, 2'd2, 2'd0, 3'd5},
      '{PF, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd12, VA, 2'd2, 2'd1, 3'd4},
      '{PF, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd24, VA, 2'd1, 2'd3, 3'd0},
      '{PF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 5'd12, VA, 2'd3, 2'd0, 3'd3},
      '{PF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd12, VA, 2'd2, 2'd3, 3'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_pte = '0;
   logic [4:0]  req_ps = 5'd12;
   logic [47:0] req_va = '0;
   logic [1:0]  req_acc = '0;
   logic [1:0]  req_plv = '0;
   logic        rsp_valid;
   logic [2:0]  rsp_fault;
   logic [47:0] rsp_pa;
   logic [2:0]  rsp_perm;

   logic        n_valid = 1'b0;
   logic [31:0] n_pte = '0;
   logic [4:0]  n_ps = 5'd12;
   logic [31:0] n_va = '0;
   logic [1:0]  n_acc = '0;
   logic [1:0]  n_plv = '0;
   logic        n_rvalid;
   logic [2:0]  n_fault;
   logic [31:0] n_pa;
   logic [2:0]  n_perm;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pte_perm_checker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pte(req_pte),
      .req_ps(req_ps), .req_va(req_va), .req_acc(req_acc), .req_plv(req_plv),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm)
   );

   pte_perm_checker #(.PTE_W(32), .VA_W(32), .PA_W(32), .FMT_WIDE(1'b0)) dut_n (
      .clk(clk), .rst_n(rst_n), .req_valid(n_valid), .req_pte(n_pte),
      .req_ps(n_ps), .req_va(n_va), .req_acc(n_acc), .req_plv(n_plv),
      .rsp_valid(n_rvalid), .rsp_fault(n_fault), .rsp_pa(n_pa), .rsp_perm(n_perm)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [47:0] ref_pa(logic [47:0] frame, logic [4:0] ps, logic [47:0] va);
      logic [47:0] m;
      m = (48'h1 << ps) - 48'h1;
      return (frame & ~m) | (va & m);
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #4_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset valid", 64'(rsp_valid), 64'd0);
      check("R1 reset fault", 64'(rsp_fault), 64'd0);
      check("R1 reset pa", 64'(rsp_pa), 64'd0);
      check("R1 reset perm", 64'(rsp_perm), 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [47:0] exp_pa;
         logic [2:0]  exp_perm;
         @(negedge clk);
         req_pte = '0;
         req_pte[47:12] = VEC[i].pfn;
         req_pte[3:2] = VEC[i].lvl;
         req_pte[0] = VEC[i].v;
         req_pte[1] = VEC[i].d;
         req_pte[62] = VEC[i].nx;
         req_pte[61] = VEC[i].nr;
         req_pte[63] = VEC[i].rp;
         req_ps = VEC[i].ps;
         req_va = VEC[i].va;
         req_acc = VEC[i].acc;
         req_plv = VEC[i].cur;
         req_valid = 1'b1;
         if (VEC[i].ef == 3'd0) begin
            exp_pa = ref_pa({VEC[i].pfn, 12'h000}, VEC[i].ps, VEC[i].va);
            exp_perm = {~VEC[i].nx, VEC[i].d, 1'b1};
         end else begin
            exp_pa = '0;
            exp_perm = '0;
         end
         @(negedge clk);
         req_valid = 1'b0;
         // R2 R3 R4 R5 R6: ordered fault code per vector
         check($sformatf("R2-R6 vec%0d fault", i), 64'(rsp_fault), 64'(VEC[i].ef));
         check($sformatf("R1 vec%0d valid", i), 64'(rsp_valid), 64'd1);
         // R8 R10: address; R9 R10: permissions
         check($sformatf("R8/R10 vec%0d pa", i), 64'(rsp_pa), 64'(exp_pa));
         check($sformatf("R9/R10 vec%0d perm", i), 64'(rsp_perm), 64'(exp_perm));
      end

      // R1: outputs hold while strobe low, inputs changing
      begin
         logic [2:0]  hf;
         logic [47:0] hp;
         logic [2:0]  hm;
         hf = rsp_fault; hp = rsp_pa; hm = rsp_perm;
         for (int k = 0; k < 3; k++) begin
            req_pte = 64'h1; req_acc = 2'd2; req_plv = 2'd3;
            @(negedge clk);
            check("R1 idle valid", 64'(rsp_valid), 64'd0);
            check("R1 hold fault", 64'(rsp_fault), 64'(hf));
            check("R1 hold pa", 64'(rsp_pa), 64'(hp));
            check("R1 hold perm", 64'(rsp_perm), 64'(hm));
         end
      end

      // R7: narrow format ignores bits that would be flags in the wide form
      @(negedge clk);
      n_pte = 32'hFFFF_F00F;
      n_ps = 5'd13; n_va = 32'h1357_9BDF; n_acc = 2'd0; n_plv = 2'd0;
      n_valid = 1'b1;
      @(negedge clk);
      n_valid = 1'b0;
      check("R7 narrow fetch fault", 64'(n_fault), 64'd0);
      check("R7 narrow perm", 64'(n_perm), 64'd7);
      check("R7 narrow pa", 64'(n_pa), 64'(32'hFFFF_E000 | 32'h0000_1BDF));
      n_pte = 32'h0000_1007;
      n_acc = 2'd1; n_plv = 2'd2;
      n_valid = 1'b1;
      @(negedge clk);
      n_valid = 1'b0;
      check("R7 narrow priv greater", 64'(n_fault), 64'd4);
      n_pte = 32'h0000_100B;
      n_acc = 2'd2; n_plv = 2'd1;
      n_valid = 1'b1;
      @(negedge clk);
      n_valid = 1'b0;
      check("R7 narrow lower level ok", 64'(n_fault), 64'd0);

      // R1: reset clears a held result
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset fault", 64'(rsp_fault), 64'd0);
      check("R1 re-reset pa", 64'(rsp_pa), 64'd0);
      finish_run();
   end

endmodule